// File: doc/BRIEF.md
# Control endpoint SETUP stage receiver

This block runs the Setup stage of one device control endpoint. It sits between a simplified packet decoder and a receive FIFO. The decoder gives it a one-cycle strobe with each 8-byte SETUP request, and a second strobe when the first IN or OUT token of the data stage arrives. For every request the block writes three 32-bit words into the FIFO: a status word, then request bytes 0 to 3, then bytes 4 to 7. When the data stage begins it writes one stage-done word.

SETUP requests are always accepted. The endpoint's NAK and enable state has no effect on them, and free FIFO space is not checked before the write. Each accepted request decrements a 2-bit setup counter that software can load, and forces NAK on both directions of the endpoint. The block also watches the words that the application pops from the FIFO. When the stage-done word is popped it raises a sticky setup interrupt and clears the OUT endpoint's enable bit. A fixed region of the FIFO is kept back for SETUP traffic: 3 words per request times three requests, plus one done word. The free space reported for data packets leaves that region out.

Top module: `ctrl_setup_rx`

## Requirements
- R1: After a SETUP strobe, the FIFO write port writes three words on three consecutive cycles, starting the cycle after the strobe. The words are, in order: the status word, `pkt_data[31:0]`, then `pkt_data[63:32]`. Status word layout: packet status in bits 20:17, byte count in bits 14:4, endpoint number in bits 3:0, all other bits zero. A SETUP word carries status 0x6 and byte count 8.
- R2: A SETUP request is written to the FIFO, with its NAK effect and counter decrement, even when both NAK bits are already set and the endpoint enable bit is 0.
- R3: `setup_cnt` decrements by one, modulo 4, on each SETUP strobe. A counter write loads `cnt_wr_val`. When a write and a SETUP strobe fall in the same cycle, the new value is `cnt_wr_val - 1`.
- R4: A SETUP strobe sets `nak_in` and `nak_out` on the next cycle. Each clear strobe clears its own bit, and the set wins when a set and a clear coincide.
- R5: The first data-stage token after a SETUP writes one stage-done word: status 0x4, byte count 0, endpoint number. A token that arrives with no open Setup stage writes nothing.
- R6: A token that arrives while a request's words are still being written delays the stage-done word. It is written on the cycle right after the last data word.
- R7: A new SETUP strobe that arrives before the stage-done word is written restarts the stage. The pending done word is dropped, and only one done word follows the next token.
- R8: Popping a word whose status field is 0x4 sets `setup_irq` and clears `ep_out_en` on the next cycle. Popping any other word changes neither.
- R9: `setup_irq` stays set until an `irq_clr` strobe. A done-word pop in the same cycle as `irq_clr` leaves it set.
- R10: `data_room` equals `fifo_free - 10`, with a floor of 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_valid | input | 1 | One-cycle strobe: a SETUP request is present |
| pkt_data | input | 64 | Request bytes, byte 0 in bits 7:0 |
| data_tok | input | 1 | One-cycle strobe: first data-stage token |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_data | output | 32 | FIFO write word |
| pop_en | input | 1 | Application popped a FIFO word this cycle |
| pop_word | input | 32 | The popped word |
| cnt_wr_en | input | 1 | Software write to the setup counter |
| cnt_wr_val | input | 2 | Value loaded by the counter write |
| setup_cnt | output | 2 | Setup counter |
| nak_in_clr | input | 1 | Software clear of the IN NAK bit |
| nak_out_clr | input | 1 | Software clear of the OUT NAK bit |
| nak_in | output | 1 | IN direction NAK |
| nak_out | output | 1 | OUT direction NAK |
| ep_en_set | input | 1 | Software set of the OUT endpoint enable bit |
| ep_out_en | output | 1 | OUT endpoint enable bit |
| irq_clr | input | 1 | Write-one clear of the setup interrupt |
| setup_irq | output | 1 | Sticky setup interrupt |
| fifo_free | input | 9 | Free FIFO words |
| data_room | output | 9 | Free words usable by data packets |

## Verification
The assertions assume that SETUP strobes are at least three cycles apart, so that one request's three words are finished before the next request arrives. They also assume that `pkt_valid` and `data_tok` are single-cycle pulses. The bench spaces every request by three or more idle cycles and raises each strobe for exactly one cycle. The restart case uses the smallest legal gap of three cycles, so that the new request lands on the cycle where the pending done word would have been written.

// File: rtl/setup_rx_pkg.sv
// Shared field positions, codes and state types for the SETUP receiver.
// Assumes a 32-bit FIFO word.
package setup_rx_pkg;
    localparam int WORD_W   = 32;
    localparam int STS_LSB  = 17;
    localparam int STS_W    = 4;
    localparam int BCNT_LSB = 4;
    localparam int BCNT_W   = 11;
    localparam int EPN_W    = 4;
    localparam int REQ_BYTES = 8;

    typedef enum logic [STS_W-1:0] {
        PS_DONE  = 4'h4,
        PS_SETUP = 4'h6
    } pkt_sts_e;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_LO   = 2'd1,
        WS_HI   = 2'd2
    } wr_state_e;

    // Builds a status word from its three fields.
    function automatic logic [WORD_W-1:0] make_status(
        input pkt_sts_e          sts,
        input logic [EPN_W-1:0]  epn,
        input logic [BCNT_W-1:0] bcnt
    );
        logic [WORD_W-1:0] w;
        w = '0;
        w[STS_LSB +: STS_W]   = sts;
        w[BCNT_LSB +: BCNT_W] = bcnt;
        w[0 +: EPN_W]         = epn;
        return w;
    endfunction
endpackage

// File: rtl/setup_word_writer.sv
// Sequences FIFO writes: three words per SETUP request and one stage-done
// word on request. Assumes SETUP strobes are at least three cycles apart.
// A done request that arrives while data words are going out is held and
// written after the last word. A new SETUP drops a held done request.
module setup_word_writer
    import setup_rx_pkg::*;
#(
    parameter int EP_NUM = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  logic [63:0]       pkt_data,
    input  logic              done_req,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_data
);
    localparam logic [EPN_W-1:0]  EPN       = EPN_W'(EP_NUM);
    localparam logic [BCNT_W-1:0] SETUP_BC  = BCNT_W'(REQ_BYTES);

    wr_state_e   state;
    logic [31:0] hi_word;
    logic [31:0] lo_word;
    logic        done_pend;

    // Write sequencer: emits the status word, the low half, the high half, then any held done word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= WS_IDLE;
            hi_word   <= '0;
            lo_word   <= '0;
            done_pend <= 1'b0;
            wr_en     <= 1'b0;
            wr_data   <= '0;
        end else if (pkt_valid) begin
            lo_word   <= pkt_data[31:0];
            hi_word   <= pkt_data[63:32];
            done_pend <= 1'b0;
            wr_en     <= 1'b1;
            wr_data   <= make_status(PS_SETUP, EPN, SETUP_BC);
            state     <= WS_LO;
        end else begin
            case (state)
                WS_LO: begin
                    wr_en   <= 1'b1;
                    wr_data <= lo_word;
                    state   <= WS_HI;
                    if (done_req) done_pend <= 1'b1;
                end
                WS_HI: begin
                    wr_en   <= 1'b1;
                    wr_data <= hi_word;
                    state   <= WS_IDLE;
                    if (done_req) done_pend <= 1'b1;
                end
                default: begin
                    if (done_pend || done_req) begin
                        wr_en     <= 1'b1;
                        wr_data   <= make_status(PS_DONE, EPN, '0);
                        done_pend <= 1'b0;
                    end else begin
                        wr_en <= 1'b0;
                    end
                    state <= WS_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/setup_stage_ctrl.sv
// Tracks the open Setup stage and holds the setup counter, both NAK bits and
// the OUT endpoint enable bit. A SETUP strobe overrides NAK and enable. The
// first token of an open stage raises a one-cycle done request, except when a
// SETUP strobe arrives in the same cycle.
module setup_stage_ctrl #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_valid,
    input  logic             data_tok,
    input  logic             cnt_wr_en,
    input  logic [CNT_W-1:0] cnt_wr_val,
    input  logic             nak_in_clr,
    input  logic             nak_out_clr,
    input  logic             ep_en_set,
    input  logic             done_popped,
    output logic             done_req,
    output logic [CNT_W-1:0] setup_cnt,
    output logic             nak_in,
    output logic             nak_out,
    output logic             ep_out_en
);
    logic             stage_open;
    logic [CNT_W-1:0] cnt_base;

    // The counter value before this cycle's decrement.
    always_comb cnt_base = cnt_wr_en ? cnt_wr_val : setup_cnt;

    // A done request only comes from an open stage with no new request in the same cycle.
    always_comb done_req = data_tok && stage_open && !pkt_valid;

    // Stage flag: opened by every SETUP, closed by the done request.
    always_ff @(posedge clk) begin
        if (!rst_n)         stage_open <= 1'b0;
        else if (pkt_valid) stage_open <= 1'b1;
        else if (done_req)  stage_open <= 1'b0;
    end

    // Setup counter: software load, then decrement modulo 2**CNT_W per SETUP.
    always_ff @(posedge clk) begin
        if (!rst_n) setup_cnt <= '0;
        else        setup_cnt <= cnt_base - (pkt_valid ? CNT_W'(1) : CNT_W'(0));
    end

    // NAK bits: a SETUP sets them and wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nak_in  <= 1'b0;
            nak_out <= 1'b0;
        end else begin
            if (pkt_valid)       nak_in <= 1'b1;
            else if (nak_in_clr) nak_in <= 1'b0;
            if (pkt_valid)        nak_out <= 1'b1;
            else if (nak_out_clr) nak_out <= 1'b0;
        end
    end

    // OUT enable: set by software, cleared when the done word is popped (the clear wins).
    always_ff @(posedge clk) begin
        if (!rst_n)           ep_out_en <= 1'b0;
        else if (done_popped) ep_out_en <= 1'b0;
        else if (ep_en_set)   ep_out_en <= 1'b1;
    end
endmodule

// File: rtl/setup_pop_watch.sv
// Watches the application's FIFO pops. When the popped word is a
// stage-done word it pulses done_popped and sets the sticky interrupt. A
// write-one clear drops the interrupt unless a new done pop falls in the
// same cycle. Assumes pop_word is valid whenever pop_en is high.
module setup_pop_watch
    import setup_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop_en,
    input  logic [WORD_W-1:0] pop_word,
    input  logic              irq_clr,
    output logic              done_popped,
    output logic              setup_irq
);
    // Decodes a popped stage-done word.
    always_comb done_popped = pop_en && (pop_word[STS_LSB +: STS_W] == PS_DONE);

    // Sticky interrupt: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)           setup_irq <= 1'b0;
        else if (done_popped) setup_irq <= 1'b1;
        else if (irq_clr)     setup_irq <= 1'b0;
    end
endmodule

// File: rtl/setup_rx_reserve.sv
// Removes the region kept back for SETUP traffic from the FIFO free count.
// Purely combinational.
module setup_rx_reserve #(
    parameter int FREE_W = 9,
    parameter int RESV   = 10
) (
    input  logic [FREE_W-1:0] fifo_free,
    output logic [FREE_W-1:0] data_room
);
    localparam logic [FREE_W-1:0] RESV_V = FREE_W'(RESV);

    // Saturating subtraction of the reserved region.
    always_comb data_room = (fifo_free > RESV_V) ? (fifo_free - RESV_V) : '0;
endmodule

// File: rtl/ctrl_setup_rx.sv
// Top level of the control endpoint SETUP receiver. It joins the stage
// control, the write sequencer, the pop watcher and the reserve
// calculation. The reserved region is three words per request for
// MAX_SETUPS back-to-back requests, plus one done word.
module ctrl_setup_rx #(
    parameter int EP_NUM     = 0,
    parameter int CNT_W      = 2,
    parameter int FREE_W     = 9,
    parameter int MAX_SETUPS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  logic [63:0]       pkt_data,
    input  logic              data_tok,
    output logic              fifo_wr_en,
    output logic [31:0]       fifo_wr_data,
    input  logic              pop_en,
    input  logic [31:0]       pop_word,
    input  logic              cnt_wr_en,
    input  logic [CNT_W-1:0]  cnt_wr_val,
    output logic [CNT_W-1:0]  setup_cnt,
    input  logic              nak_in_clr,
    input  logic              nak_out_clr,
    output logic              nak_in,
    output logic              nak_out,
    input  logic              ep_en_set,
    output logic              ep_out_en,
    input  logic              irq_clr,
    output logic              setup_irq,
    input  logic [FREE_W-1:0] fifo_free,
    output logic [FREE_W-1:0] data_room
);
    localparam int WORDS_PER_REQ = 3;
    localparam int RESV_WORDS    = WORDS_PER_REQ * MAX_SETUPS + 1;

    logic done_req;
    logic done_popped;

    setup_stage_ctrl #(.CNT_W(CNT_W)) u_stage (
        .clk(clk), .rst_n(rst_n),
        .pkt_valid(pkt_valid), .data_tok(data_tok),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_val(cnt_wr_val),
        .nak_in_clr(nak_in_clr), .nak_out_clr(nak_out_clr),
        .ep_en_set(ep_en_set), .done_popped(done_popped),
        .done_req(done_req), .setup_cnt(setup_cnt),
        .nak_in(nak_in), .nak_out(nak_out), .ep_out_en(ep_out_en)
    );

    setup_word_writer #(.EP_NUM(EP_NUM)) u_writer (
        .clk(clk), .rst_n(rst_n),
        .pkt_valid(pkt_valid), .pkt_data(pkt_data),
        .done_req(done_req),
        .wr_en(fifo_wr_en), .wr_data(fifo_wr_data)
    );

    setup_pop_watch u_pop (
        .clk(clk), .rst_n(rst_n),
        .pop_en(pop_en), .pop_word(pop_word),
        .irq_clr(irq_clr),
        .done_popped(done_popped), .setup_irq(setup_irq)
    );

    setup_rx_reserve #(.FREE_W(FREE_W), .RESV(RESV_WORDS)) u_resv (
        .fifo_free(fifo_free), .data_room(data_room)
    );
endmodule

// File: rtl/ctrl_setup_rx_chk.sv
// Assertion checker bound to ctrl_setup_rx. It sees only the top-level
// ports and assumes single-cycle strobes with SETUPs at least three cycles
// apart.
module ctrl_setup_rx_chk #(
    parameter int CNT_W  = 2,
    parameter int FREE_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pkt_valid,
    input logic              fifo_wr_en,
    input logic [31:0]       fifo_wr_data,
    input logic              pop_en,
    input logic [31:0]       pop_word,
    input logic              cnt_wr_en,
    input logic [CNT_W-1:0]  cnt_wr_val,
    input logic [CNT_W-1:0]  setup_cnt,
    input logic              nak_in,
    input logic              nak_out,
    input logic              ep_out_en,
    input logic              irq_clr,
    input logic              setup_irq,
    input logic [FREE_W-1:0] fifo_free,
    input logic [FREE_W-1:0] data_room
);
    // R1
    setup_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> fifo_wr_en && fifo_wr_data[20:17] == 4'h6 && fifo_wr_data[14:4] == 11'd8);

    // R1
    setup_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pkt_valid) |=> fifo_wr_en);

    // R3
    setup_cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> setup_cnt == CNT_W'($past(cnt_wr_en ? cnt_wr_val : setup_cnt) - 1'b1));

    // R4
    nak_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> nak_in && nak_out);

    // R8
    done_pop_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && pop_word[20:17] == 4'h4) |=> setup_irq && !ep_out_en);

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(setup_irq) |-> $past(pop_en && pop_word[20:17] == 4'h4));

    // R9
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(setup_irq) |-> $past(irq_clr));

    // R10
    room_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_room <= fifo_free);
endmodule

bind ctrl_setup_rx ctrl_setup_rx_chk #(.CNT_W(CNT_W), .FREE_W(FREE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid),
    .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
    .pop_en(pop_en), .pop_word(pop_word),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_val(cnt_wr_val), .setup_cnt(setup_cnt),
    .nak_in(nak_in), .nak_out(nak_out), .ep_out_en(ep_out_en),
    .irq_clr(irq_clr), .setup_irq(setup_irq),
    .fifo_free(fifo_free), .data_room(data_room)
);

// File: tb/ctrl_setup_rx_tb.sv
// Directed bench for ctrl_setup_rx. Inputs change on the falling edge. A
// monitor logs every FIFO write at the rising edge.
module ctrl_setup_rx_tb;
    localparam int EPN = 3;
    localparam logic [31:0] ST_SETUP = (32'h6 << 17) | (32'd8 << 4) | EPN;
    localparam logic [31:0] ST_DONE  = (32'h4 << 17) | EPN;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_valid = 1'b0;
    logic [63:0] pkt_data = '0;
    logic        data_tok = 1'b0;
    logic        fifo_wr_en;
    logic [31:0] fifo_wr_data;
    logic        pop_en = 1'b0;
    logic [31:0] pop_word = '0;
    logic        cnt_wr_en = 1'b0;
    logic [1:0]  cnt_wr_val = '0;
    logic [1:0]  setup_cnt;
    logic        nak_in_clr = 1'b0;
    logic        nak_out_clr = 1'b0;
    logic        nak_in, nak_out;
    logic        ep_en_set = 1'b0;
    logic        ep_out_en;
    logic        irq_clr = 1'b0;
    logic        setup_irq;
    logic [8:0]  fifo_free = 9'd100;
    logic [8:0]  data_room;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] wlog [0:63];
    int wcnt = 0;

    always #10 clk = ~clk;

    ctrl_setup_rx #(.EP_NUM(EPN)) u_dut (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
        .data_tok(data_tok), .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
        .pop_en(pop_en), .pop_word(pop_word), .cnt_wr_en(cnt_wr_en),
        .cnt_wr_val(cnt_wr_val), .setup_cnt(setup_cnt), .nak_in_clr(nak_in_clr),
        .nak_out_clr(nak_out_clr), .nak_in(nak_in), .nak_out(nak_out),
        .ep_en_set(ep_en_set), .ep_out_en(ep_out_en), .irq_clr(irq_clr),
        .setup_irq(setup_irq), .fifo_free(fifo_free), .data_room(data_room)
    );

    // Logs every FIFO write.
    always @(posedge clk) begin
        if (rst_n && fifo_wr_en && wcnt < 64) begin
            wlog[wcnt] = fifo_wr_data;
            wcnt = wcnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_setup(input logic [63:0] d);
        @(negedge clk);
        pkt_valid = 1'b1;
        pkt_data  = d;
        @(negedge clk);
        pkt_valid = 1'b0;
    endtask

    task automatic pulse_tok();
        @(negedge clk);
        data_tok = 1'b1;
        @(negedge clk);
        data_tok = 1'b0;
    endtask

    task automatic pop(input logic [31:0] w, input logic clr);
        @(negedge clk);
        pop_en = 1'b1; pop_word = w; irq_clr = clr;
        @(negedge clk);
        pop_en = 1'b0; irq_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset wr_en", fifo_wr_en, 0);
        chk("R3 reset cnt", setup_cnt, 0);
        chk("R4 reset nak", {nak_in, nak_out}, 0);
        chk("R9 reset irq", setup_irq, 0);
    endtask

    task automatic t_words();
        int b = wcnt;
        @(negedge clk); cnt_wr_en = 1'b1; cnt_wr_val = 2'd3;
        @(negedge clk); cnt_wr_en = 1'b0;
        chk("R3 load", setup_cnt, 3);
        pulse_setup(64'h8877_6655_4433_2211);
        chk("R4 nak set", {nak_in, nak_out}, 2'b11);
        idle(4);
        chk("R1 count", wcnt - b, 3);
        chk("R1 status", wlog[b], ST_SETUP);
        chk("R1 low", wlog[b+1], 32'h4433_2211);
        chk("R1 high", wlog[b+2], 32'h8877_6655);
        chk("R3 dec", setup_cnt, 2);
    endtask

    task automatic t_override();
        int b = wcnt;
        pulse_setup(64'hDEAD_BEEF_0BAD_F00D);
        idle(4);
        chk("R2 count", wcnt - b, 3);
        chk("R2 low", wlog[b+1], 32'h0BAD_F00D);
        chk("R2 high", wlog[b+2], 32'hDEAD_BEEF);
        chk("R2 cnt", setup_cnt, 1);
        pulse_setup(64'h1); idle(4);
        chk("R3 to zero", setup_cnt, 0);
        pulse_setup(64'h2); idle(4);
        chk("R3 wrap", setup_cnt, 3);
        @(negedge clk); cnt_wr_en = 1'b1; cnt_wr_val = 2'd2; pkt_valid = 1'b1;
        @(negedge clk); cnt_wr_en = 1'b0; pkt_valid = 1'b0;
        chk("R3 load with setup", setup_cnt, 1);
        idle(4);
    endtask

    task automatic t_nak_clr();
        @(negedge clk); nak_in_clr = 1'b1;
        @(negedge clk); nak_in_clr = 1'b0;
        chk("R4 in clr", {nak_in, nak_out}, 2'b01);
        @(negedge clk); nak_out_clr = 1'b1; pkt_valid = 1'b1;
        @(negedge clk); nak_out_clr = 1'b0; pkt_valid = 1'b0;
        chk("R4 set wins", {nak_in, nak_out}, 2'b11);
        idle(4);
    endtask

    task automatic t_done();
        int b = wcnt;
        pulse_tok();
        idle(2);
        chk("R5 one marker", wcnt - b, 1);
        chk("R5 marker word", wlog[b], ST_DONE);
        b = wcnt;
        pulse_tok();
        idle(3);
        chk("R5 stray token", wcnt - b, 0);
    endtask

    task automatic t_pending();
        int b = wcnt;
        pulse_setup(64'h55);
        data_tok = 1'b1;
        @(negedge clk); data_tok = 1'b0;
        idle(4);
        chk("R6 count", wcnt - b, 4);
        chk("R6 order", wlog[b+3], ST_DONE);
        chk("R6 high first", wlog[b+2], 32'h0);
    endtask

    task automatic t_restart();
        int b = wcnt;
        pulse_setup(64'h11);
        data_tok = 1'b1;
        @(negedge clk); data_tok = 1'b0;
        @(negedge clk); pkt_valid = 1'b1; pkt_data = 64'h22;
        @(negedge clk); pkt_valid = 1'b0;
        idle(5);
        chk("R7 no marker", wcnt - b, 6);
        pulse_tok(); idle(2);
        chk("R7 single marker", wcnt - b, 7);
        chk("R7 marker word", wlog[b+6], ST_DONE);
    endtask

    task automatic t_irq();
        @(negedge clk); ep_en_set = 1'b1;
        @(negedge clk); ep_en_set = 1'b0;
        chk("R8 en set", ep_out_en, 1);
        pop(ST_SETUP, 1'b0);
        chk("R8 data pop irq", setup_irq, 0);
        chk("R8 data pop en", ep_out_en, 1);
        pop(ST_DONE, 1'b0);
        chk("R8 irq", setup_irq, 1);
        chk("R8 en cleared", ep_out_en, 0);
        idle(3);
        chk("R9 sticky", setup_irq, 1);
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        chk("R9 clear", setup_irq, 0);
        pop(ST_DONE, 1'b1);
        chk("R9 set wins", setup_irq, 1);
    endtask

    task automatic t_room();
        @(negedge clk); fifo_free = 9'd20; #1;
        chk("R10 20", data_room, 10);
        fifo_free = 9'd10; #1;
        chk("R10 10", data_room, 0);
        fifo_free = 9'd5; #1;
        chk("R10 5", data_room, 0);
        fifo_free = 9'd511; #1;
        chk("R10 511", data_room, 501);
    endtask

    initial begin
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(1);
        t_words();
        t_override();
        t_nak_clr();
        t_done();
        t_pending();
        t_restart();
        t_irq();
        t_room();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule